// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-add unit that computes z + x*y, or z - x*y when the subtract variant is selected. It sorts each of the three operands into one of six classes: zero, normal, denormal, infinity, quiet NaN or signaling NaN. From those classes it decides whether the answer is already fixed by the special-value rules. If it is, the result is presented as a bypass word with an invalid-operation flag. If it is not, the operation is handed to the arithmetic datapath. The handoff carries the product sign, the accumulator sign and zero flag, and a normalized 24-bit mantissa and unbiased signed exponent for each operand. Denormal operands are normalized on the way.

Operands enter on a valid/ready stream and leave on another, through one register stage. A transfer occurs on a clock edge where valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and the consumer holds ready low, the output word stays frozen and no new operand is taken. Rounding and the arithmetic itself belong to the downstream datapath.

Top module: `fmar_resolver`

## Requirements
- R1: A signaling-NaN accumulator takes precedence over every other operand. The result is the accumulator with its quiet bit (fraction bit 22) set, and the invalid flag is raised.
- R2: If the accumulator is not a signaling NaN, a signaling-NaN x is returned quieted with invalid raised. If only y is a signaling NaN, y is returned quieted with invalid raised, even when x is a quiet NaN.
- R3: With no signaling NaN present, a quiet-NaN x is returned unchanged in preference to a quiet-NaN y or accumulator. A quiet-NaN y is returned in preference to a quiet-NaN accumulator. Invalid stays low in both cases.
- R4: Infinity times zero, in either order, returns a quiet-NaN accumulator unchanged. Otherwise it raises invalid and returns the default NaN 0x7FC00000.
- R5: An infinite product is infinity times a nonzero finite value, or infinity times infinity. It returns a quiet-NaN accumulator unchanged. If the accumulator is infinite with the opposite sign to the product, the result is invalid and the default NaN. Otherwise the result is infinity (exponent all ones, fraction zero) carrying the product sign.
- R6: When the product is zero (zero times zero, or zero times finite), an infinite accumulator yields infinity with the accumulator's sign. Any other accumulator word is returned bit for bit.
- R7: When both product operands are finite and nonzero, a quiet-NaN accumulator is returned, and an infinite accumulator yields infinity with its own sign. Otherwise bypass is low and proceed is high.
- R8: In the subtract variant the product sign (x sign xor y sign) is inverted before every sign decision and on the product-sign output.
- R9: On proceed, each mantissa output has bit 23 set and each exponent output is the unbiased signed exponent. A normal operand gives biased exponent minus 127. A denormal is shifted left until bit 23 is set and its exponent lowered to match, so 0x00000001 gives mantissa 0x800000 and exponent -149. The accumulator zero flag is high for a zero accumulator.
- R10: Every accepted operation produces exactly one of bypass or proceed, and invalid is raised only together with bypass and a quiet-NaN result.
- R11: in_ready equals not out_valid or out_ready. An operand accepted at one edge is valid at the output after that edge. The output holds every field stable while out_valid is high and out_ready is low.
- R12: During and just after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand triple is valid |
| in_ready | output | 1 | Block can take an operand triple |
| in_sub | input | 1 | High selects z - x*y |
| in_x | input | 32 | First product operand |
| in_y | input | 32 | Second product operand |
| in_z | input | 32 | Accumulator operand |
| out_valid | output | 1 | Output fields are valid |
| out_ready | input | 1 | Consumer takes the output |
| out_bypass | output | 1 | Result is fixed by special-value rules |
| out_result | output | 32 | Bypass result word |
| out_invalid | output | 1 | Invalid-operation flag |
| out_proceed | output | 1 | Arithmetic datapath must compute |
| out_psign | output | 1 | Effective product sign |
| out_zsign | output | 1 | Accumulator sign |
| out_zzero | output | 1 | Accumulator is zero |
| out_xexp | output | 10 | Unbiased signed exponent of x |
| out_xman | output | 24 | Normalized mantissa of x |
| out_yexp | output | 10 | Unbiased signed exponent of y |
| out_yman | output | 24 | Normalized mantissa of y |
| out_zexp | output | 10 | Unbiased signed exponent of z |
| out_zman | output | 24 | Normalized mantissa of z |

## Verification
The bench sets NaN operands against each other in every precedence pairing. A resolver with the wrong operand order would return the wrong payload, and one that skipped quieting would return a signaling pattern. It covers infinity times zero and infinities of opposite sign, with and without a quiet-NaN accumulator. A design missing either rule would emit infinity or drop the invalid flag. The subtract variant is driven against infinite accumulators, where an uninverted product sign flips both the result sign and the invalid decision. The bench also checks denormal normalization at both extremes of the fraction, and holds the output stalled while a second operand waits, so that an off-by-one shift or a register that overwrites under back-pressure shows up.

// File: rtl/fmar_pkg.sv
package fmar_pkg;

  // Operand classes used by the precedence logic.
  typedef enum logic [2:0] {
    CL_ZERO  = 3'd0,
    CL_NORM  = 3'd1,
    CL_DNORM = 3'd2,
    CL_INF   = 3'd3,
    CL_QNAN  = 3'd4,
    CL_SNAN  = 3'd5
  } fmar_cls_e;

  localparam int NUM_OPS = 3;
  localparam int OP_X = 0;
  localparam int OP_Y = 1;
  localparam int OP_Z = 2;

endpackage

// File: rtl/fmar_classify.sv
module fmar_classify
  import fmar_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W      = 1 + EXP_W + MAN_W,
  localparam int EXPO_W = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic [W-1:0]            op_i,
  output fmar_cls_e               cls_o,
  output logic                    sign_o,
  output logic signed [EXPO_W-1:0] exp_o,
  output logic [MAN_W:0]          man_o
);

  logic [EXP_W-1:0] bexp;
  logic [MAN_W-1:0] frac;
  int               lead;

  assign bexp   = op_i[W-2:MAN_W];
  assign frac   = op_i[MAN_W-1:0];
  assign sign_o = op_i[W-1];

  // Leading-zero count of the fraction field.
  function automatic int count_lead(input logic [MAN_W-1:0] f);
    int  n;
    logic seen;
    n = 0;
    seen = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!seen) begin
        if (f[i]) seen = 1'b1;
        else      n = n + 1;
      end
    end
    return n;
  endfunction

  assign lead = count_lead(frac);

  always_comb begin
    cls_o = CL_NORM;
    exp_o = '0;
    man_o = '0;
    if (bexp == '1) begin
      if (frac == '0)           cls_o = CL_INF;
      else if (frac[MAN_W-1])   cls_o = CL_QNAN;
      else                      cls_o = CL_SNAN;
    end else if (bexp == '0) begin
      if (frac == '0) begin
        cls_o = CL_ZERO;
        exp_o = EXPO_W'(-BIAS);
      end else begin
        cls_o = CL_DNORM;
        man_o = {1'b0, frac} << (lead + 1);
        exp_o = EXPO_W'(-BIAS - lead);
      end
    end else begin
      cls_o = CL_NORM;
      man_o = {1'b1, frac};
      exp_o = EXPO_W'(int'(bexp) - BIAS);
    end
  end

endmodule

// File: rtl/fmar_decide.sv
module fmar_decide
  import fmar_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  fmar_cls_e      xc_i,
  input  fmar_cls_e      yc_i,
  input  fmar_cls_e      zc_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [W-1:0]   z_i,
  input  logic           sub_i,
  output logic [W-1:0]   result_o,
  output logic           bypass_o,
  output logic           invalid_o,
  output logic           proceed_o,
  output logic           psign_o
);

  localparam logic [MAN_W-1:0] QBIT = MAN_W'(1) << (MAN_W - 1);
  localparam logic [W-1:0]     DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, QBIT};

  function automatic logic [W-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] quieten(input logic [W-1:0] v);
    return v | {{(1 + EXP_W){1'b0}}, QBIT};
  endfunction

  logic x_fin_nz, y_fin_nz, zs, ps;
  logic inf_zero, prod_inf, prod_zero;

  assign x_fin_nz = (xc_i == CL_NORM) || (xc_i == CL_DNORM);
  assign y_fin_nz = (yc_i == CL_NORM) || (yc_i == CL_DNORM);
  assign zs       = z_i[W-1];
  assign ps       = x_i[W-1] ^ y_i[W-1] ^ sub_i;
  assign psign_o  = ps;

  assign inf_zero  = ((xc_i == CL_INF) && (yc_i == CL_ZERO)) ||
                     ((xc_i == CL_ZERO) && (yc_i == CL_INF));
  assign prod_inf  = ((xc_i == CL_INF) && (y_fin_nz || (yc_i == CL_INF))) ||
                     ((yc_i == CL_INF) && x_fin_nz);
  assign prod_zero = ((xc_i == CL_ZERO) && ((yc_i == CL_ZERO) || y_fin_nz)) ||
                     ((yc_i == CL_ZERO) && x_fin_nz);

  always_comb begin
    result_o  = '0;
    bypass_o  = 1'b1;
    invalid_o = 1'b0;
    proceed_o = 1'b0;
    if (zc_i == CL_SNAN) begin
      invalid_o = 1'b1;
      result_o  = quieten(z_i);
    end else if (xc_i == CL_SNAN) begin
      invalid_o = 1'b1;
      result_o  = quieten(x_i);
    end else if (yc_i == CL_SNAN) begin
      invalid_o = 1'b1;
      result_o  = quieten(y_i);
    end else if (xc_i == CL_QNAN) begin
      result_o = x_i;
    end else if (yc_i == CL_QNAN) begin
      result_o = y_i;
    end else if (inf_zero) begin
      if (zc_i == CL_QNAN) begin
        result_o = z_i;
      end else begin
        invalid_o = 1'b1;
        result_o  = DEFAULT_NAN;
      end
    end else if (prod_inf) begin
      if (zc_i == CL_QNAN) begin
        result_o = z_i;
      end else if ((zc_i == CL_INF) && (zs != ps)) begin
        invalid_o = 1'b1;
        result_o  = DEFAULT_NAN;
      end else begin
        result_o = make_inf(ps);
      end
    end else if (prod_zero) begin
      if (zc_i == CL_INF) result_o = make_inf(zs);
      else                result_o = z_i;
    end else begin
      if (zc_i == CL_QNAN) begin
        result_o = z_i;
      end else if (zc_i == CL_INF) begin
        result_o = make_inf(zs);
      end else begin
        bypass_o  = 1'b0;
        proceed_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fmar_resolver.sv
module fmar_resolver
  import fmar_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W      = 1 + EXP_W + MAN_W,
  localparam int EXPO_W = EXP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_sub,
  input  logic [W-1:0]             in_x,
  input  logic [W-1:0]             in_y,
  input  logic [W-1:0]             in_z,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_bypass,
  output logic [W-1:0]             out_result,
  output logic                     out_invalid,
  output logic                     out_proceed,
  output logic                     out_psign,
  output logic                     out_zsign,
  output logic                     out_zzero,
  output logic signed [EXPO_W-1:0] out_xexp,
  output logic [MAN_W:0]           out_xman,
  output logic signed [EXPO_W-1:0] out_yexp,
  output logic [MAN_W:0]           out_yman,
  output logic signed [EXPO_W-1:0] out_zexp,
  output logic [MAN_W:0]           out_zman
);

  logic [W-1:0]             ops  [NUM_OPS];
  fmar_cls_e                cls  [NUM_OPS];
  logic                     sgn  [NUM_OPS];
  logic signed [EXPO_W-1:0] nexp [NUM_OPS];
  logic [MAN_W:0]           nman [NUM_OPS];

  assign ops[OP_X] = in_x;
  assign ops[OP_Y] = in_y;
  assign ops[OP_Z] = in_z;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fmar_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g]),
      .sign_o(sgn[g]),
      .exp_o (nexp[g]),
      .man_o (nman[g])
    );
  end

  logic [W-1:0] d_result;
  logic         d_bypass, d_invalid, d_proceed, d_psign;

  fmar_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
    .xc_i     (cls[OP_X]),
    .yc_i     (cls[OP_Y]),
    .zc_i     (cls[OP_Z]),
    .x_i      (in_x),
    .y_i      (in_y),
    .z_i      (in_z),
    .sub_i    (in_sub),
    .result_o (d_result),
    .bypass_o (d_bypass),
    .invalid_o(d_invalid),
    .proceed_o(d_proceed),
    .psign_o  (d_psign)
  );

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_bypass  <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_proceed <= 1'b0;
      out_psign   <= 1'b0;
      out_zsign   <= 1'b0;
      out_zzero   <= 1'b0;
      out_xexp    <= '0;
      out_xman    <= '0;
      out_yexp    <= '0;
      out_yman    <= '0;
      out_zexp    <= '0;
      out_zman    <= '0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_bypass  <= d_bypass;
      out_result  <= d_result;
      out_invalid <= d_invalid;
      out_proceed <= d_proceed;
      out_psign   <= d_psign;
      out_zsign   <= sgn[OP_Z];
      out_zzero   <= (cls[OP_Z] == CL_ZERO);
      out_xexp    <= nexp[OP_X];
      out_xman    <= nman[OP_X];
      out_yexp    <= nexp[OP_Y];
      out_yman    <= nman[OP_Y];
      out_zexp    <= nexp[OP_Z];
      out_zman    <= nman[OP_Z];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fmar_resolver_chk.sv
module fmar_resolver_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_bypass,
  input logic         out_invalid,
  input logic         out_proceed,
  input logic [W-1:0] out_result,
  input logic [MAN_W:0] out_xman,
  input logic [MAN_W:0] out_yman,
  input logic [MAN_W:0] out_zman
);

  p_one_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bypass ^ out_proceed));

  p_invalid_nan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |->
      (out_bypass && (out_result[W-2:MAN_W] == '1) && out_result[MAN_W-1]));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_bypass) &&
       $stable(out_invalid) && $stable(out_zman)));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_proceed) |-> (out_xman[MAN_W] && out_yman[MAN_W]));

endmodule

bind fmar_resolver fmar_resolver_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_bypass (out_bypass),
  .out_invalid(out_invalid),
  .out_proceed(out_proceed),
  .out_result (out_result),
  .out_xman   (out_xman),
  .out_yman   (out_yman),
  .out_zman   (out_zman)
);

// File: tb/fmar_resolver_test.sv
module fmar_resolver_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sub = 1'b0, out_ready = 1'b1;
  logic [31:0] in_x = '0, in_y = '0, in_z = '0;
  logic        in_ready, out_valid, out_bypass, out_invalid, out_proceed;
  logic        out_psign, out_zsign, out_zzero;
  logic [31:0] out_result;
  logic signed [9:0] out_xexp, out_yexp, out_zexp;
  logic [23:0] out_xman, out_yman, out_zman;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fmar_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_bypass(out_bypass),
    .out_result(out_result), .out_invalid(out_invalid), .out_proceed(out_proceed),
    .out_psign(out_psign), .out_zsign(out_zsign), .out_zzero(out_zzero),
    .out_xexp(out_xexp), .out_xman(out_xman), .out_yexp(out_yexp),
    .out_yman(out_yman), .out_zexp(out_zexp), .out_zman(out_zman)
  );

  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] NONE = 32'hBF80_0000, THREE = 32'h4040_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] DEN = 32'h0000_0001, DNAN = 32'h7FC0_0000;
  localparam logic [31:0] SNX = 32'h7F80_0005, SNY = 32'h7F80_0006, SNZ = 32'h7F80_0007;
  localparam logic [31:0] QNX = 32'h7FC0_0002, QNY = 32'h7FC0_0003, QNZ = 32'h7FC0_0004;

  // {req[3:0], sub, x, y, z, result, bypass, invalid}
  localparam int NV = 22;
  localparam logic [134:0] VEC [NV] = '{
    {4'd1,  1'b0, SNX,  ONE,  SNZ,  32'h7FC0_0007, 1'b1, 1'b1}, // R1
    {4'd2,  1'b0, SNX,  SNY,  ONE,  32'h7FC0_0005, 1'b1, 1'b1}, // R2
    {4'd2,  1'b0, QNX,  SNY,  ONE,  32'h7FC0_0006, 1'b1, 1'b1}, // R2
    {4'd2,  1'b0, ONE,  SNY,  QNZ,  32'h7FC0_0006, 1'b1, 1'b1}, // R2
    {4'd3,  1'b0, QNX,  QNY,  QNZ,  QNX,           1'b1, 1'b0}, // R3
    {4'd3,  1'b0, ONE,  QNY,  QNZ,  QNY,           1'b1, 1'b0}, // R3
    {4'd4,  1'b0, PINF, PZ,   ONE,  DNAN,          1'b1, 1'b1}, // R4
    {4'd4,  1'b0, PZ,   NINF, QNZ,  QNZ,           1'b1, 1'b0}, // R4
    {4'd5,  1'b0, PINF, NONE, ONE,  NINF,          1'b1, 1'b0}, // R5
    {4'd5,  1'b0, PINF, PINF, QNZ,  QNZ,           1'b1, 1'b0}, // R5
    {4'd5,  1'b0, PINF, ONE,  NINF, DNAN,          1'b1, 1'b1}, // R5
    {4'd5,  1'b0, PINF, ONE,  PINF, PINF,          1'b1, 1'b0}, // R5
    {4'd6,  1'b0, PZ,   ONE,  NINF, NINF,          1'b1, 1'b0}, // R6
    {4'd6,  1'b0, NZ,   DEN,  THREE, THREE,        1'b1, 1'b0}, // R6
    {4'd6,  1'b0, PZ,   PZ,   QNZ,  QNZ,           1'b1, 1'b0}, // R6
    {4'd7,  1'b0, ONE,  TWO,  QNZ,  QNZ,           1'b1, 1'b0}, // R7
    {4'd7,  1'b0, ONE,  TWO,  NINF, NINF,          1'b1, 1'b0}, // R7
    {4'd7,  1'b0, ONE,  TWO,  ONE,  32'h0,         1'b0, 1'b0}, // R7
    {4'd8,  1'b1, PINF, ONE,  ONE,  NINF,          1'b1, 1'b0}, // R8
    {4'd8,  1'b1, PINF, ONE,  NINF, NINF,          1'b1, 1'b0}, // R8
    {4'd8,  1'b1, PINF, ONE,  PINF, DNAN,          1'b1, 1'b1}, // R8
    {4'd7,  1'b0, DEN,  ONE,  ONE,  32'h0,         1'b0, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic sub, input logic [31:0] x, input logic [31:0] y,
                      input logic [31:0] z);
    @(negedge clk);
    in_valid = 1'b1; in_sub = sub; in_x = x; in_y = y; in_z = z;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", {30'd0, out_valid, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {30'd0, out_valid, in_ready}, 32'h1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [134:0] v;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[134:131], i);
      send(v[130], v[129:98], v[97:66], v[65:34]);
      check(tag, {31'd0, out_valid}, 32'h1);
      check(tag, {30'd0, out_bypass, out_invalid}, {30'd0, v[1], v[0]});
      check({tag, " R10"}, {31'd0, out_proceed}, {31'd0, ~v[1]});
      if (v[1]) check(tag, out_result, v[33:2]);
    end

    // R9: denormal normalization on proceed
    send(1'b0, DEN, 32'h0040_0000, ONE);
    check("R9 xman", {8'd0, out_xman}, 32'h0080_0000);
    check("R9 xexp", 32'(int'(out_xexp)), 32'(-149));
    check("R9 yman", {8'd0, out_yman}, 32'h0080_0000);
    check("R9 yexp", 32'(int'(out_yexp)), 32'(-127));
    check("R9 zexp", 32'(int'(out_zexp)), 32'd0);
    check("R9 zman", {8'd0, out_zman}, 32'h0080_0000);
    check("R9 zzero", {31'd0, out_zzero}, 32'd0);

    // R8: subtract inverts product sign on proceed output
    send(1'b1, ONE, TWO, NZ);
    check("R8 psign", {29'd0, out_proceed, out_psign, out_zsign}, 32'h7);
    check("R9 zzero", {31'd0, out_zzero}, 32'd1);
    send(1'b0, NONE, TWO, ONE);
    check("R8 psign", {31'd0, out_psign}, 32'd1);

    // R11: back-pressure holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sub = 1'b0; in_x = PINF; in_y = PZ; in_z = ONE;
    @(posedge clk);
    @(negedge clk);
    check("R11 stall ready", {30'd0, out_valid, in_ready}, 32'h2);
    in_x = ONE; in_y = QNY; in_z = QNZ;
    repeat (3) @(negedge clk);
    check("R11 hold", out_result, DNAN);
    check("R11 hold valid", {30'd0, out_valid, in_ready}, 32'h2);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next", out_result, QNY);
    @(negedge clk);
    check("R11 drain", {30'd0, out_valid, in_ready}, 32'h1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule